// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a tick timer with two registers. Software reaches them through a single-cycle write port and two read-back buses. The control register holds a two-bit operating mode, an interrupt-enable bit, an interrupt-pending bit and a 28-bit period. The count register is a 32-bit up-counter.

Each cycle the low 28 bits of the registered count are compared with the period. When they are equal, the selected mode decides what the counter does next. It can hold its value, return to zero or keep counting. In a disabled timer it does not count at all.

A match sets the pending bit only while interrupt-enable is set. The interrupt line is a level, so a pending bit that software leaves set keeps the line high. A timer that stays on its match value sets the pending bit again after software clears it. An external exception-enable input masks the line without affecting the pending bit.

Top module: `tick_timer`

## Requirements
- R1: After reset both registers read zero and the interrupt line is low. The control register is laid out as mode in bits 31:30 (00 off, 01 restart, 10 one-shot, 11 free-run), interrupt-enable in bit 29, pending in bit 28 and period in bits 27:0. A write with `wr_addr`=0 loads the control register and a write with `wr_addr`=1 loads the count.
- R2: In off mode the count does not change unless the count register is written.
- R3: A control-register write never loads the count. On the write edge the count takes the step that the old mode dictates. After that edge it follows the new mode from the value it holds.
- R4: In free-run mode the count rises by one on every edge, including through and past the match value.
- R5: In one-shot mode the count stops on the match value and stays there, and the mode field keeps reading one-shot.
- R6: In restart mode the count goes to zero on the edge after a match and counts up again, giving periodic matches.
- R7: A match sets the pending bit on the following edge if interrupt-enable is set. With interrupt-enable clear, a match leaves the pending bit clear.
- R8: Writing 0 to the pending bit clears it on the write edge. If the count still matches while interrupt-enable is set, the bit is set again on the next edge.
- R9: Only the low 28 bits of the count take part in the match. A count loaded above the period runs on, carries into bit 28 and matches when its low bits equal the period.
- R10: A count-register write wins over the increment in the same cycle, and counting goes on from the written value.
- R11: With interrupt-enable set, a count equal to the period sets the pending bit even in off mode. This holds whether the count or the control register was written last.
- R12: The interrupt line is the AND of pending, interrupt-enable and `exc_en`. With `exc_en` low the pending bit is kept but the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the count |
| wr_data | input | 32 | Write data |
| exc_en | input | 1 | External tick-exception enable |
| mode_rd | output | 32 | Control register read-back |
| count_rd | output | 32 | Count register read-back |
| irq | output | 1 | Level interrupt request |

## Verification
Each of the four modes is run over a cycle-by-cycle sweep from a known count, with the expected count worked out arithmetically as k, min(k, P) or k mod (P+1). A wrong stop, restart or hold rule therefore shows up on the exact cycle it goes wrong. Each mode is also tried with interrupt-enable both set and clear. This separates the rule that a match sets the pending bit from the rule that an enable gates it. Directed patterns then cover a count loaded near the 28-bit boundary, both write orders for a match in off mode, and a count write that collides with an increment. The exc_en mask is toggled while the pending bit is held.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_RESTART = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_FREE    = 2'b11
    } tick_mode_e;

    localparam int CTRL_FLAG_BITS = 4;

endpackage

// File: rtl/tick_match.sv
module tick_match #(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic [CNT_W-1:0] count,
    input  logic [PER_W-1:0] period,
    output logic             hit
);
    generate
        if (CNT_W == PER_W) begin : g_full
            assign hit = (count == period);
        end else begin : g_low
            // upper count bits are left out of the comparison (R9)
            assign hit = (count[PER_W-1:0] == period);
        end
    endgenerate
endmodule

// File: rtl/tick_count_step.sv
module tick_count_step
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  tick_mode_e       mode,
    input  logic             hit,
    input  logic [CNT_W-1:0] count,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_nx
);
    logic [CNT_W-1:0] count_inc;

    assign count_inc = count + CNT_W'(1);

    always_comb begin
        if (load) begin
            count_nx = load_val;                    // R10: load beats increment
        end else begin
            unique case (mode)
                MODE_OFF:     count_nx = count;
                MODE_RESTART: count_nx = hit ? '0 : count_inc;
                MODE_ONESHOT: count_nx = hit ? count : count_inc;
                MODE_FREE:    count_nx = count_inc;
                default:      count_nx = count;
            endcase
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             exc_en,
    output logic [REG_W-1:0] mode_rd,
    output logic [REG_W-1:0] count_rd,
    output logic             irq
);
    localparam int PER_W  = REG_W - CTRL_FLAG_BITS;
    localparam int MODE_H = REG_W - 1;
    localparam int IE_B   = REG_W - 3;
    localparam int IP_B   = REG_W - 4;

    typedef struct packed {
        tick_mode_e       mode;
        logic             ie;
        logic             ip;
        logic [PER_W-1:0] period;
        logic [REG_W-1:0] count;
    } tick_state_t;

    tick_state_t      st_d, st_q;
    logic             hit;
    logic             wr_ctrl, wr_cnt;
    logic [REG_W-1:0] count_nx;

    assign wr_ctrl = wr_en && !wr_addr;
    assign wr_cnt  = wr_en &&  wr_addr;

    tick_match #(.CNT_W(REG_W), .PER_W(PER_W)) match_i (
        .count  (st_q.count),
        .period (st_q.period),
        .hit    (hit)
    );

    tick_count_step #(.CNT_W(REG_W)) step_i (
        .mode     (st_q.mode),
        .hit      (hit),
        .count    (st_q.count),
        .load     (wr_cnt),
        .load_val (wr_data),
        .count_nx (count_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.count = count_nx;
        if (wr_ctrl) begin
            st_d.mode   = tick_mode_e'(wr_data[MODE_H -: 2]);
            st_d.ie     = wr_data[IE_B];
            st_d.ip     = wr_data[IP_B];
            st_d.period = wr_data[PER_W-1:0];
        end else if (hit && st_q.ie) begin
            st_d.ip = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_rd  = {st_q.mode, st_q.ie, st_q.ip, st_q.period};
    assign count_rd = st_q.count;
    assign irq      = st_q.ip & st_q.ie & exc_en;

    p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF && !wr_cnt) |=> $stable(count_rd));

    p_ctrl_wr_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && st_q.mode == MODE_OFF) |=> $stable(count_rd));

    p_free_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_FREE && !wr_cnt) |=> (count_rd == $past(count_rd) + REG_W'(1)));

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ONESHOT && hit && !wr_cnt) |=> $stable(count_rd));

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RESTART && hit && !wr_cnt) |=> (count_rd == '0));

    p_ip_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.ie && !wr_ctrl) |=> mode_rd[IP_B]);

    p_ip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ie && !st_q.ip && !wr_ctrl) |=> !mode_rd[IP_B]);

    p_cnt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count_rd == $past(wr_data)));

endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        exc_en = 1'b1;
    logic [31:0] mode_rd, count_rd;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .exc_en(exc_en), .mode_rd(mode_rd),
        .count_rd(count_rd), .irq(irq)
    );

    function automatic logic [31:0] ctrl(input logic [1:0] m, input logic ie,
                                         input logic ip, input logic [27:0] per);
        return {m, ie, ip, per};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_eq("R1 ctrl", mode_rd, 32'h0);
        chk_eq("R1 count", count_rd, 32'h0);
        chk_eq("R1 irq", {31'h0, irq}, 32'h0);

        // R2 off mode holds
        tick(10);
        chk_eq("R2 off hold", count_rd, 32'h0);
        wr(1'b1, 32'd5);
        chk_eq("R10 load", count_rd, 32'd5);
        tick(7);
        chk_eq("R2 off hold after load", count_rd, 32'd5);

        // R4 free-run sweep, no enable
        wr(1'b0, ctrl(2'b11, 1'b0, 1'b0, 28'd8));
        chk_eq("R3 ctrl write keeps count", count_rd, 32'd5);
        for (int k = 1; k <= 20; k++) begin
            tick(1);
            chk_eq("R4 free count", count_rd, 32'd5 + 32'(k));
            chk_eq("R7 no enable no pending", {31'h0, mode_rd[28]}, 32'h0);
        end

        // R3 stop and resume
        wr(1'b0, ctrl(2'b00, 1'b0, 1'b0, 28'd8));
        chk_eq("R3 step under old mode", count_rd, 32'd26);
        tick(5);
        chk_eq("R2 held", count_rd, 32'd26);
        wr(1'b0, ctrl(2'b11, 1'b0, 1'b0, 28'd8));
        chk_eq("R3 resume edge", count_rd, 32'd26);
        tick(1);
        chk_eq("R3 resumed", count_rd, 32'd27);

        // R5 one-shot sweep
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
        wr(1'b0, ctrl(2'b10, 1'b1, 1'b0, 28'd6));
        for (int k = 1; k <= 12; k++) begin
            tick(1);
            chk_eq("R5 one-shot count", count_rd, (k < 6) ? 32'(k) : 32'd6);
            chk_eq("R7 pending", {31'h0, mode_rd[28]}, (k >= 7) ? 32'h1 : 32'h0);
            chk_eq("R12 irq", {31'h0, irq}, (k >= 7) ? 32'h1 : 32'h0);
        end
        chk_eq("R5 mode field", {30'h0, mode_rd[31:30]}, 32'h2);

        // R8 clear and re-set
        wr(1'b0, ctrl(2'b10, 1'b1, 1'b0, 28'd6));
        chk_eq("R8 cleared", {31'h0, mode_rd[28]}, 32'h0);
        tick(1);
        chk_eq("R8 re-set", {31'h0, mode_rd[28]}, 32'h1);

        // R12 masking
        exc_en = 1'b0;
        tick(1);
        chk_eq("R12 pending kept", {31'h0, mode_rd[28]}, 32'h1);
        chk_eq("R12 masked", {31'h0, irq}, 32'h0);
        exc_en = 1'b1;
        tick(1);
        chk_eq("R12 unmasked", {31'h0, irq}, 32'h1);
        wr(1'b0, ctrl(2'b10, 1'b0, 1'b1, 28'd6));
        chk_eq("R12 ie low", {31'h0, irq}, 32'h0);
        tick(2);
        chk_eq("R12 pending stays", {31'h0, mode_rd[28]}, 32'h1);
        chk_eq("R5 still stopped", count_rd, 32'd6);

        // R6 restart sweep
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
        wr(1'b0, ctrl(2'b01, 1'b1, 1'b0, 28'd4));
        for (int k = 1; k <= 20; k++) begin
            tick(1);
            chk_eq("R6 restart count", count_rd, 32'(k % 5));
            chk_eq("R6 pending", {31'h0, mode_rd[28]}, (k >= 5) ? 32'h1 : 32'h0);
        end

        // R7 one-shot without enable
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
        wr(1'b0, ctrl(2'b10, 1'b0, 1'b0, 28'd3));
        tick(10);
        chk_eq("R7 count stopped", count_rd, 32'd3);
        chk_eq("R7 no pending", {31'h0, mode_rd[28]}, 32'h0);
        chk_eq("R7 no irq", {31'h0, irq}, 32'h0);

        // R9 low-bit wrap
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h1FFF_FFFC);
        wr(1'b0, ctrl(2'b10, 1'b1, 1'b0, 28'd2));
        tick(3);
        chk_eq("R9 high count", count_rd, 32'h1FFF_FFFF);
        chk_eq("R9 no early match", {31'h0, mode_rd[28]}, 32'h0);
        tick(3);
        chk_eq("R9 carry", count_rd, 32'h2000_0002);
        tick(5);
        chk_eq("R9 stopped", count_rd, 32'h2000_0002);
        chk_eq("R9 pending", {31'h0, mode_rd[28]}, 32'h1);

        // R11 off-mode match, both orders
        wr(1'b0, 32'h0);
        wr(1'b1, 32'd7);
        wr(1'b0, ctrl(2'b00, 1'b1, 1'b0, 28'd7));
        chk_eq("R11 clear on write", {31'h0, mode_rd[28]}, 32'h0);
        tick(1);
        chk_eq("R11 ctrl last", {31'h0, mode_rd[28]}, 32'h1);
        chk_eq("R11 count held", count_rd, 32'd7);
        wr(1'b0, ctrl(2'b00, 1'b1, 1'b0, 28'd9));
        tick(2);
        chk_eq("R11 no match", {31'h0, mode_rd[28]}, 32'h0);
        wr(1'b1, 32'd9);
        chk_eq("R11 not yet", {31'h0, mode_rd[28]}, 32'h0);
        tick(1);
        chk_eq("R11 count last", {31'h0, mode_rd[28]}, 32'h1);
        chk_eq("R11 count held 9", count_rd, 32'd9);

        // R10 load wins while free-running
        wr(1'b0, ctrl(2'b11, 1'b0, 1'b0, 28'h100));
        tick(4);
        chk_eq("R10 running", count_rd, 32'd13);
        wr(1'b1, 32'h50);
        chk_eq("R10 load wins", count_rd, 32'h50);
        tick(3);
        chk_eq("R10 continue", count_rd, 32'h53);

        // R4 free-run with enable passes match
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
        wr(1'b0, ctrl(2'b11, 1'b1, 1'b0, 28'd4));
        tick(4);
        chk_eq("R4 at match", count_rd, 32'd4);
        chk_eq("R7 not yet", {31'h0, mode_rd[28]}, 32'h0);
        tick(1);
        chk_eq("R4 past match", count_rd, 32'd5);
        chk_eq("R7 set", {31'h0, mode_rd[28]}, 32'h1);
        tick(3);
        chk_eq("R4 keeps going", count_rd, 32'd8);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule